// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash bus and turns one high-level request into the full bus conversation the flash expects. A request names an operation (erase one block, erase a whole bank, program one word, set a block lock, or clear all locks), a target address and, for programming, a data word. The sequencer then drives the chip-enable, write-strobe and output-enable lines with timing counted in clock cycles. It first waits until the flash reports ready, issues the two command cycles of the operation, and waits again for ready. It then decodes the final status byte bit by bit and returns the flash to array-read mode.

The outcome is reported as a 3-bit result code with a one-cycle valid pulse. On any failure, including a poll timeout, the sequencer writes the clear-status command before the read-array command, so the device is left clean for the next request. Unused operation codes are rejected at once and produce no bus activity.

Top module: `nor_op_sequencer`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe` is low, `req_ready` is 1, `res_valid` is 0 and `res_code` is 0.
- R2: Every accepted operation begins with a write of 70h, followed by status reads that repeat until bit 7 of the low data byte reads 1.
- R3: Once ready is seen, the command pair is written. Op 0 (block erase) writes 20h then D0h. Op 1 (bank erase) writes 30h then D0h. Op 2 (program) writes 40h then the request data. Op 3 (lock set) writes 60h then 01h. Op 4 (lock clear) writes 60h then D0h.
- R4: After the command pair, status is polled again until bit 7 is 1. A clean status then leads to a single FFh write and result code 0.
- R5: The final status byte is decoded in this priority: bit 3 gives code 1 (supply fault), bit 1 gives code 2 (protected), bits 5 and 4 both set give code 3 (bad sequence), bit 5 alone gives code 4 (erase fault), and bit 4 alone gives code 5 (program fault).
- R6: With any non-zero result other than 7, the last two writes are 50h and then FFh.
- R7: If MAX_POLLS consecutive status reads in either poll phase all show bit 7 at 0, the operation ends with code 6. A ready seen on read MAX_POLLS itself still succeeds.
- R8: Op codes 5 to 7 produce code 7 on the next cycle's `res_valid` with no bus cycle at all.
- R9: In a write cycle, CE falls one cycle before WE. WE stays low for exactly WE_LOW_CYC cycles. Address and data are held and driven for the whole CE-low window. WE and OE are never low together, and CE stays high for at least one cycle between cycles.
- R10: `res_valid` is a one-cycle pulse. `res_code` changes only with that pulse and holds otherwise. `req_ready` is low while an operation is in progress.
- R11: Every bus cycle of an operation uses the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 3 | Operation code (0 to 4 valid) |
| req_addr | input | ADDR_W | Target address |
| req_data | input | DQ_W | Word to program (op 2) |
| res_valid | output | 1 | One-cycle completion pulse |
| res_code | output | 3 | Result code, held until next completion |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | DQ_W | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for write data |
| fl_dq_lo_in | input | 8 | Low data byte read from flash (status) |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench models the flash status so it can stay busy for a chosen number of reads in each poll phase. While the device is busy in the second phase, the model shows error bits together with bit 7 low. A design that decodes status before ready would therefore report a false error. Status bytes with several error bits set check the decode priority; a wrong order would return, for example, a program fault where a supply fault is due. Busy counts equal to MAX_POLLS and one below it test the timeout boundary from both sides, where an off-by-one either aborts a good operation or polls once too often. The bench also checks the exact write-byte sequence for every op, the 50h write before FFh on failure, and the WE low width; a missing clear-status or a shortened strobe shows up there as a wrong or extra write.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [2:0] OPC_ERASE_BLK  = 3'd0;
  localparam logic [2:0] OPC_ERASE_BANK = 3'd1;
  localparam logic [2:0] OPC_PROGRAM    = 3'd2;
  localparam logic [2:0] OPC_LOCK_SET   = 3'd3;
  localparam logic [2:0] OPC_LOCK_CLR   = 3'd4;

  localparam logic [2:0] RES_OK       = 3'd0;
  localparam logic [2:0] RES_SUPPLY   = 3'd1;
  localparam logic [2:0] RES_PROTECT  = 3'd2;
  localparam logic [2:0] RES_SEQUENCE = 3'd3;
  localparam logic [2:0] RES_ERASE    = 3'd4;
  localparam logic [2:0] RES_PROGRAM  = 3'd5;
  localparam logic [2:0] RES_TIMEOUT  = 3'd6;
  localparam logic [2:0] RES_BAD_OP   = 3'd7;

  localparam logic [7:0] BYTE_STATUS  = 8'h70;
  localparam logic [7:0] BYTE_CLEAR   = 8'h50;
  localparam logic [7:0] BYTE_ARRAY   = 8'hFF;
  localparam logic [7:0] BYTE_CONFIRM = 8'hD0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_STAT_CMD, SQ_POLL_PRE, SQ_CMD_A, SQ_CMD_B,
    SQ_POLL_POST, SQ_CLEAR, SQ_ARRAY
  } seq_state_e;

  typedef enum logic [1:0] {BP_IDLE, BP_SETUP, BP_ACTIVE, BP_HOLD} bus_phase_e;

  function automatic logic [7:0] lead_byte(input logic [2:0] op);
    case (op)
      OPC_ERASE_BLK:  lead_byte = 8'h20;
      OPC_ERASE_BANK: lead_byte = 8'h30;
      OPC_PROGRAM:    lead_byte = 8'h40;
      default:        lead_byte = 8'h60;
    endcase
  endfunction

  function automatic logic [7:0] trail_byte(input logic [2:0] op);
    trail_byte = (op == OPC_LOCK_SET) ? 8'h01 : BYTE_CONFIRM;
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int ADDR_W     = 21,
  parameter int DQ_W       = 16,
  parameter int WE_LOW_CYC = 3,
  parameter int RD_LOW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   data_i,
  output logic              done,
  output logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DQ_W-1:0]   bus_dq,
  output logic              bus_dq_oe,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  input  logic [7:0]        bus_lo_in
);
  import nor_seq_pkg::*;

  localparam int MAXC = (WE_LOW_CYC > RD_LOW_CYC) ? WE_LOW_CYC : RD_LOW_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WE_LAST = CW'(WE_LOW_CYC - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_LOW_CYC - 1);

  bus_phase_e    phase;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [CW-1:0] last;

  assign last = wr_q ? WE_LAST : RD_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= BP_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      bus_addr  <= '0;
      bus_dq    <= '0;
      bus_dq_oe <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      done      <= 1'b0;
      rd_byte   <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        BP_IDLE: if (start) begin
          bus_addr  <= addr_i;
          bus_dq    <= is_write ? data_i : '0;
          wr_q      <= is_write;
          bus_dq_oe <= is_write;
          ce_n      <= 1'b0;
          phase     <= BP_SETUP;
        end
        BP_SETUP: begin
          if (wr_q) we_n <= 1'b0;
          else      oe_n <= 1'b0;
          cnt   <= '0;
          phase <= BP_ACTIVE;
        end
        BP_ACTIVE: begin
          if (cnt == last) begin
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            if (!wr_q) rd_byte <= bus_lo_in;
            phase <= BP_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ce_n      <= 1'b1;
          bus_dq_oe <= 1'b0;
          done      <= 1'b1;
          phase     <= BP_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_poll_limit.sv
module nor_poll_limit #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic at_limit
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] LAST = PW'(MAX_POLLS - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == LAST);
endmodule

// File: rtl/nor_status_decode.sv
module nor_status_decode (
  input  logic [7:0] sr,
  output logic [2:0] code
);
  import nor_seq_pkg::*;

  always_comb begin
    if (sr[3])              code = RES_SUPPLY;
    else if (sr[1])         code = RES_PROTECT;
    else if (sr[5] && sr[4]) code = RES_SEQUENCE;
    else if (sr[5])         code = RES_ERASE;
    else if (sr[4])         code = RES_PROGRAM;
    else                    code = RES_OK;
  end
endmodule

// File: rtl/nor_op_sequencer.sv
module nor_op_sequencer #(
  parameter int ADDR_W     = 21,
  parameter int DQ_W       = 16,
  parameter int WE_LOW_CYC = 3,
  parameter int RD_LOW_CYC = 2,
  parameter int MAX_POLLS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_data,
  output logic              res_valid,
  output logic [2:0]        res_code,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DQ_W-1:0]   fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_lo_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  import nor_seq_pkg::*;

  localparam int PAD = DQ_W - 8;

  seq_state_e        st;
  logic              pend;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   data_q;
  logic [2:0]        err_q;
  logic              res_valid_q;
  logic [2:0]        res_code_q;

  logic              bus_start, bus_wr, bus_done;
  logic [DQ_W-1:0]   bus_wdata;
  logic [7:0]        bus_rbyte;
  logic              polling, poll_clear, poll_step, at_limit;
  logic [2:0]        dec_code;

  assign polling   = (st == SQ_POLL_PRE) || (st == SQ_POLL_POST);
  assign bus_start = (st != SQ_IDLE) && !pend;
  assign bus_wr    = !polling;

  always_comb begin
    case (st)
      SQ_STAT_CMD: bus_wdata = {{PAD{1'b0}}, BYTE_STATUS};
      SQ_CMD_A:    bus_wdata = {{PAD{1'b0}}, lead_byte(op_q)};
      SQ_CMD_B:    bus_wdata = (op_q == OPC_PROGRAM) ? data_q
                                                     : {{PAD{1'b0}}, trail_byte(op_q)};
      SQ_CLEAR:    bus_wdata = {{PAD{1'b0}}, BYTE_CLEAR};
      SQ_ARRAY:    bus_wdata = {{PAD{1'b0}}, BYTE_ARRAY};
      default:     bus_wdata = '0;
    endcase
  end

  assign poll_clear = bus_done && ((st == SQ_STAT_CMD) || (st == SQ_CMD_B));
  assign poll_step  = bus_done && polling && !bus_rbyte[7] && !at_limit;

  nor_bus_cycle #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W),
    .WE_LOW_CYC(WE_LOW_CYC), .RD_LOW_CYC(RD_LOW_CYC)
  ) u_bus (
    .clk(clk), .rst(rst),
    .start(bus_start), .is_write(bus_wr),
    .addr_i(addr_q), .data_i(bus_wdata),
    .done(bus_done), .rd_byte(bus_rbyte),
    .bus_addr(fl_addr), .bus_dq(fl_dq_out), .bus_dq_oe(fl_dq_oe),
    .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
    .bus_lo_in(fl_dq_lo_in)
  );

  nor_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst(rst), .clear(poll_clear), .step(poll_step), .at_limit(at_limit)
  );

  nor_status_decode u_dec (.sr(bus_rbyte), .code(dec_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      pend        <= 1'b0;
      op_q        <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      err_q       <= RES_OK;
      res_valid_q <= 1'b0;
      res_code_q  <= RES_OK;
    end else begin
      res_valid_q <= 1'b0;
      if (bus_start) pend <= 1'b1;
      if (bus_done)  pend <= 1'b0;
      case (st)
        SQ_IDLE: if (req_valid) begin
          if (req_op > OPC_LOCK_CLR) begin
            res_valid_q <= 1'b1;
            res_code_q  <= RES_BAD_OP;
          end else begin
            op_q   <= req_op;
            addr_q <= req_addr;
            data_q <= req_data;
            err_q  <= RES_OK;
            st     <= SQ_STAT_CMD;
          end
        end
        SQ_STAT_CMD: if (bus_done) st <= SQ_POLL_PRE;
        SQ_POLL_PRE: if (bus_done) begin
          if (bus_rbyte[7]) st <= SQ_CMD_A;
          else if (at_limit) begin
            err_q <= RES_TIMEOUT;
            st    <= SQ_CLEAR;
          end
        end
        SQ_CMD_A: if (bus_done) st <= SQ_CMD_B;
        SQ_CMD_B: if (bus_done) st <= SQ_POLL_POST;
        SQ_POLL_POST: if (bus_done) begin
          if (bus_rbyte[7]) begin
            err_q <= dec_code;
            st    <= (dec_code == RES_OK) ? SQ_ARRAY : SQ_CLEAR;
          end else if (at_limit) begin
            err_q <= RES_TIMEOUT;
            st    <= SQ_CLEAR;
          end
        end
        SQ_CLEAR: if (bus_done) st <= SQ_ARRAY;
        default: if (bus_done) begin
          res_valid_q <= 1'b1;
          res_code_q  <= err_q;
          st          <= SQ_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (st == SQ_IDLE);
  assign res_valid = res_valid_q;
  assign res_code  = res_code_q;
endmodule

// File: rtl/nor_op_sequencer_chk.sv
module nor_op_sequencer_chk #(
  parameter int ADDR_W = 21,
  parameter int DQ_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              res_valid,
  input logic [2:0]        res_code,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DQ_W-1:0]   fl_dq_out,
  input logic              fl_dq_oe,
  input logic              fl_ce_n,
  input logic              fl_we_n,
  input logic              fl_oe_n
);
  assert_we_within_ce_R9: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);

  assert_we_oe_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  assert_we_fall_after_ce_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> $past(!fl_ce_n));

  assert_bus_held_R9: assert property (@(posedge clk) disable iff (rst)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_oe_n);

  assert_ce_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_ce_n) |=> fl_ce_n);

  assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> fl_ce_n);

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_code_held_R10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_code));
endmodule

bind nor_op_sequencer nor_op_sequencer_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .res_valid(res_valid),
  .res_code(res_code), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
  .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/tb_nor_op_sequencer.sv
`timescale 1ns/1ps
module tb_nor_op_sequencer;
  localparam int AW = 21, DW = 16, WEC = 3, RDC = 2, MAXP = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic res_valid;
  logic [2:0] res_code;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out;
  logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
  logic [7:0] fl_dq_lo_in;

  nor_op_sequencer #(.ADDR_W(AW), .DQ_W(DW), .WE_LOW_CYC(WEC),
                     .RD_LOW_CYC(RDC), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .res_valid(res_valid), .res_code(res_code), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_lo_in(fl_dq_lo_in),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_item_t;
  wr_item_t   exp_wr[$];
  logic [2:0] exp_res[$];
  string      wr_tag = "R3";
  string      res_tag = "R4";
  int checks = 0, fails = 0, res_seen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash status model
  int pre_busy = 0, post_busy = 0, rd_pre = 0, rd_post = 0, wr_cnt = 0;
  logic [7:0] final_sr = 8'h80;
  logic [7:0] sr_now;
  always_comb begin
    if (wr_cnt >= 3) sr_now = (rd_post < post_busy) ? (final_sr & 8'h7F) : (final_sr | 8'h80);
    else             sr_now = (rd_pre < pre_busy) ? 8'h00 : 8'h80;
  end
  assign fl_dq_lo_in = fl_oe_n ? 8'h00 : sr_now;

  always @(posedge fl_oe_n) if (!rst) begin
    if (wr_cnt >= 3) rd_post++;
    else             rd_pre++;
  end

  // write monitor (scoreboard pop)
  always @(posedge fl_we_n) if (!rst) begin
    wr_item_t e;
    wr_cnt++;
    check(!fl_ce_n && fl_dq_oe, "R9", "ce/drive at strobe rise", {fl_ce_n, fl_dq_oe}, 2'b01);
    if (exp_wr.size() == 0) begin
      check(1'b0, wr_tag, "unexpected write", fl_dq_out, 0);
    end else begin
      e = exp_wr.pop_front();
      check(fl_dq_out == e.d, wr_tag, "write data", fl_dq_out, e.d);
      check(fl_addr == e.a, "R11", "write address", fl_addr, e.a);
    end
  end

  // strobe width monitor
  int low_cnt = 0;
  always @(negedge clk) if (!rst) begin
    if (!fl_we_n) low_cnt++;
    else if (low_cnt != 0) begin
      check(low_cnt == WEC, "R9", "WE low cycles", low_cnt, WEC);
      low_cnt = 0;
    end
  end

  // result monitor
  always @(negedge clk) if (!rst && res_valid) begin
    if (exp_res.size() == 0) check(1'b0, res_tag, "unexpected result", res_code, 0);
    else begin
      logic [2:0] r;
      r = exp_res.pop_front();
      check(res_code == r, res_tag, "result code", res_code, r);
    end
    res_seen++;
  end

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_item_t it;
    it.a = a; it.d = d;
    exp_wr.push_back(it);
  endtask

  task automatic run_op(input string wtag, input string rtag, input logic [2:0] op,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int pre, input int post, input logic [7:0] sr,
                        input logic [2:0] exp_code);
    int seen0;
    logic [7:0] c1, c2;
    case (op)
      3'd0: begin c1 = 8'h20; c2 = 8'hD0; end
      3'd1: begin c1 = 8'h30; c2 = 8'hD0; end
      3'd2: begin c1 = 8'h40; c2 = 8'h00; end
      3'd3: begin c1 = 8'h60; c2 = 8'h01; end
      default: begin c1 = 8'h60; c2 = 8'hD0; end
    endcase
    if (op <= 3'd4) begin
      push_wr(a, 16'h0070);
      if (pre < MAXP) begin
        push_wr(a, {8'h00, c1});
        push_wr(a, (op == 3'd2) ? d : {8'h00, c2});
      end
      if (exp_code != 3'd0) push_wr(a, 16'h0050);
      push_wr(a, 16'h00FF);
    end
    exp_res.push_back(exp_code);
    pre_busy = pre; post_busy = post; final_sr = sr;
    rd_pre = 0; rd_post = 0; wr_cnt = 0;
    wr_tag = wtag; res_tag = rtag;
    seen0 = res_seen;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (op <= 3'd4) check(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
    while (res_seen == seen0) @(negedge clk);
    check(exp_wr.size() == 0, wtag, "writes outstanding", exp_wr.size(), 0);
    if (op <= 3'd4) begin
      check(rd_pre == ((pre < MAXP) ? pre + 1 : MAXP), "R2", "status reads before command",
            rd_pre, (pre < MAXP) ? pre + 1 : MAXP);
      if (pre < MAXP)
        check(rd_post == ((post < MAXP) ? post + 1 : MAXP), (post < MAXP) ? "R4" : "R7",
              "status reads after command", rd_post, (post < MAXP) ? post + 1 : MAXP);
    end else begin
      check(wr_cnt == 0 && rd_pre == 0, "R8", "bus cycles on bad op", wr_cnt + rd_pre, 0);
    end
    repeat (4) @(negedge clk);
    check(res_code == exp_code, "R10", "code held", res_code, exp_code);
    check(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    check(!fl_dq_oe, "R1", "dq drive", fl_dq_oe, 0);
    check(req_ready && !res_valid, "R1", "ready/valid", {req_ready, res_valid}, 2'b10);
    check(res_code == 3'd0, "R1", "code", res_code, 0);

    // R3/R4 clean ops of each kind
    run_op("R3", "R4", 3'd0, 21'h050000, 16'h0, 2, 3, 8'h80, 3'd0);
    run_op("R3", "R4", 3'd1, 21'h1F0000, 16'h0, 0, 1, 8'h80, 3'd0);
    run_op("R3", "R4", 3'd2, 21'h012345, 16'hBEEF, 1, 2, 8'h80, 3'd0);
    run_op("R3", "R4", 3'd3, 21'h0A0000, 16'h0, 0, 0, 8'h80, 3'd0);
    run_op("R3", "R4", 3'd4, 21'h000000, 16'h0, 0, 0, 8'h80, 3'd0);
    // R5/R6 decode priority and clear-status on error
    run_op("R6", "R5", 3'd2, 21'h003000, 16'h1234, 0, 2, 8'h9A, 3'd1);
    run_op("R6", "R5", 3'd0, 21'h020000, 16'h0, 1, 1, 8'hB2, 3'd2);
    run_op("R6", "R5", 3'd0, 21'h030000, 16'h0, 0, 3, 8'hB0, 3'd3);
    run_op("R6", "R5", 3'd1, 21'h100000, 16'h0, 0, 3, 8'hA0, 3'd4);
    run_op("R6", "R5", 3'd2, 21'h004444, 16'h5A5A, 0, 1, 8'h90, 3'd5);
    // R7 timeout boundaries
    run_op("R6", "R7", 3'd0, 21'h060000, 16'h0, MAXP, 0, 8'h80, 3'd6);
    run_op("R3", "R7", 3'd0, 21'h070000, 16'h0, MAXP - 1, MAXP - 1, 8'h80, 3'd0);
    run_op("R6", "R7", 3'd3, 21'h080000, 16'h0, 0, MAXP, 8'h80, 3'd6);
    // R8 unused op codes
    run_op("R8", "R8", 3'd6, 21'h090000, 16'h0, 0, 0, 8'h80, 3'd7);
    run_op("R8", "R8", 3'd5, 21'h091000, 16'h0, 0, 0, 8'h80, 3'd7);
    // R11 after a bad op, a normal op still works at its own address
    run_op("R11", "R4", 3'd2, 21'h1ABCDE, 16'h00C3, 0, 0, 8'h80, 3'd0);
    report();
    $finish;
  end
endmodule